// File: doc/BRIEF.md
# Host-Managed Memory Range Decoder Register Set

This block holds a small array of memory range decoders behind a plain 32-bit register port. Each decoder has a 64-bit base, a 64-bit size and a control word. The control word carries an interleave grain code, an interleave ways code, a lock flag, a commit request, two result flags (committed and commit error) and a target type bit. Software first programs a decoder and then raises its commit request. One cycle later the block checks the encodings, the alignment of the range and the ordering against the decoder below. It then reports either committed or commit error.

A committed decoder presents its base, its size, its grain in bytes and its way count on dedicated output buses, ready for the routing logic elsewhere. A committed decoder that also has its lock flag set is frozen until reset. A read-only capability word and a global control word with a single enable bit complete the map. Reads are combinational from the address.

Top module: `hdm_decoder_regs`

## Requirements
- R1: After reset every decoder register, every result flag, the enable bit and every decoder output bus reads zero, and any earlier lock is gone.
- R2: Offset 0x0 is read-only. It returns a decoder-count code in bits 3:0 (0 means one decoder, n means 2n decoders), the target count in bits 7:4, support for interleave on address bits 11:8 in bit 8, and support for address bits 14:12 in bit 9.
- R3: Offset 0x4 stores only bit 1 (the enable). All other bits read zero.
- R4: Decoder i has base low at 0x20*i+0x10, base high at +0x14, size low at +0x18, size high at +0x1C and control at 0x20*i+0x20. Control bits are: grain 3:0, ways 7:4, lock 8, commit 9, committed 10, error 11, type 12. All registers read back what was written.
- R5: A control write that takes commit from 0 to 1 starts a check. On the next clock the decoder sets exactly one of committed or error. A committed decoder drives its base, size, grain bytes and way count on the outputs. An uncommitted decoder drives zeros.
- R6: Grain codes 0 to 6 decode to 256 << g bytes. Codes 7 to 15 make the commit fail.
- R7: Ways codes 0 to 4 decode to 1 << w. Codes 8 to 10 decode to 3, 6 or 12. Every other ways code makes the commit fail.
- R8: A base or size with any of bits 27:0 set (not 256 MB aligned) makes the commit fail.
- R9: For i > 0, a commit fails if decoder i-1 is not committed, or if base i lies below base(i-1) + size(i-1).
- R10: A control write with commit 0 clears committed and error.
- R11: While a decoder is committed with lock set, writes to its base, size and control registers are ignored, including writes that clear commit.
- R12: Software cannot write the committed and error bits. A control write with commit 1 while commit is already 1 starts no new check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| decCommitted | output | NUM_DEC | Per-decoder committed flag |
| decBase | output | NUM_DEC*64 | Committed base per decoder |
| decSize | output | NUM_DEC*64 | Committed size per decoder |
| decGranBytes | output | NUM_DEC*32 | Committed interleave grain in bytes |
| decWays | output | NUM_DEC*5 | Committed interleave way count |

## Verification
The hardest state to reach is a committed decoder whose neighbour conditions differ. The bench has to build a committed lower decoder, then commit the next one against it, once below its end and once flush with it. It also has to commit while the lower decoder is still clear. The stimulus gets there by clearing and re-arming commit around each attempt, so that every attempt is a fresh 0-to-1 edge. It walks all sixteen grain codes and all sixteen ways codes this way, then locks a committed decoder and tries every kind of write against it. A behavioural model tracks every clock and is compared with all output buses at every falling edge.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

  localparam int CTL_GRAIN_LSB = 0;
  localparam int CTL_WAYS_LSB  = 4;
  localparam int CTL_LOCK      = 8;
  localparam int CTL_COMMIT    = 9;
  localparam int CTL_DONE      = 10;
  localparam int CTL_FAIL      = 11;
  localparam int CTL_TYPE      = 12;

  // Per-decoder strobes from control to datapath
  typedef struct packed {
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrSizeLo;
    logic wrSizeHi;
    logic wrCtrl;
    logic evalNow;
    logic dropCommit;
  } decStrobe_t;

  function automatic logic grainLegal(input logic [3:0] g);
    return g <= 4'd6;
  endfunction

  function automatic logic waysLegal(input logic [3:0] w);
    return (w <= 4'd4) || (w >= 4'd8 && w <= 4'd10);
  endfunction

  function automatic logic [31:0] grainBytes(input logic [3:0] g);
    return grainLegal(g) ? (32'd256 << g) : 32'd0;
  endfunction

  function automatic logic [4:0] wayCount(input logic [3:0] w);
    logic [4:0] r;
    if (w <= 4'd4)                   r = 5'd1 << w;
    else if (w >= 4'd8 && w <= 4'd10) r = 5'd3 << (w - 4'd8);
    else                             r = 5'd0;
    return r;
  endfunction

endpackage

// File: rtl/hdm_ctrl.sv
module hdm_ctrl
  import hdm_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               commitReqBit,
  input  logic [NUM_DEC-1:0] commitBit,
  input  logic [NUM_DEC-1:0] locked,
  output decStrobe_t         strobes [NUM_DEC],
  output logic               globWr
);

  localparam int STRIDE   = 32;
  localparam int FIRST_OF = 16;

  logic [NUM_DEC-1:0] evalQ;

  assign globWr = wrEn && (addr == ADDR_W'(4));

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    localparam int OFF = STRIDE * i + FIRST_OF;
    logic sel;
    logic hitCtrl;
    logic armHit;

    assign sel     = wrEn && !locked[i];
    assign hitCtrl = addr == ADDR_W'(OFF + 16);
    assign armHit  = sel && hitCtrl && commitReqBit && !commitBit[i];

    always_comb begin
      strobes[i].wrBaseLo   = sel && (addr == ADDR_W'(OFF));
      strobes[i].wrBaseHi   = sel && (addr == ADDR_W'(OFF + 4));
      strobes[i].wrSizeLo   = sel && (addr == ADDR_W'(OFF + 8));
      strobes[i].wrSizeHi   = sel && (addr == ADDR_W'(OFF + 12));
      strobes[i].wrCtrl     = sel && hitCtrl;
      strobes[i].evalNow    = evalQ[i];
      strobes[i].dropCommit = sel && hitCtrl && !commitReqBit;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evalQ[i] <= 1'b0;
      else       evalQ[i] <= armHit;
    end

    // R12
    eval_needs_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
      evalQ[i] |-> commitBit[i]);
  end

endmodule

// File: rtl/hdm_datapath.sv
module hdm_datapath
  import hdm_pkg::*;
#(
  parameter int NUM_DEC    = 4,
  parameter int ADDR_W     = 8,
  parameter int TGT_CNT    = 1,
  parameter bit SUP_LOW_IG = 1'b1,
  parameter bit SUP_HI_IG  = 1'b0,
  parameter int ALIGN_BITS = 28
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  decStrobe_t            strobes [NUM_DEC],
  input  logic                  globWr,
  input  logic [31:0]           wrData,
  input  logic [ADDR_W-1:0]     addr,
  output logic [31:0]           rdData,
  output logic [NUM_DEC-1:0]    commitBit,
  output logic [NUM_DEC-1:0]    locked,
  output logic [NUM_DEC-1:0]    decCommitted,
  output logic [NUM_DEC*64-1:0] decBase,
  output logic [NUM_DEC*64-1:0] decSize,
  output logic [NUM_DEC*32-1:0] decGranBytes,
  output logic [NUM_DEC*5-1:0]  decWays
);

  localparam logic [3:0] CNT_CODE = (NUM_DEC == 1) ? 4'd0 : 4'(NUM_DEC / 2);
  localparam logic [31:0] CAP_WORD =
    {22'd0, SUP_HI_IG, SUP_LOW_IG, 4'(TGT_CNT), CNT_CODE};

  logic [63:0] baseReg [NUM_DEC];
  logic [63:0] sizeReg [NUM_DEC];
  logic [3:0]  grainCode [NUM_DEC];
  logic [3:0]  waysCode [NUM_DEC];
  logic [NUM_DEC-1:0] lockBit, commitReg, doneReg, failReg, typeBit, passAll;
  logic enableReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       enableReg <= 1'b0;
    else if (globWr) enableReg <= wrData[1];
  end

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic prevOk;
    logic aligned;

    if (i == 0) begin : g_first
      assign prevOk = 1'b1;
    end else begin : g_rest
      assign prevOk = doneReg[i-1] && (baseReg[i] >= baseReg[i-1] + sizeReg[i-1]);
    end

    assign aligned = (baseReg[i][ALIGN_BITS-1:0] == '0) &&
                     (sizeReg[i][ALIGN_BITS-1:0] == '0);
    assign passAll[i] = grainLegal(grainCode[i]) && waysLegal(waysCode[i]) &&
                        aligned && prevOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[i]   <= '0;
        sizeReg[i]   <= '0;
        grainCode[i] <= '0;
        waysCode[i]  <= '0;
        lockBit[i]   <= 1'b0;
        commitReg[i] <= 1'b0;
        typeBit[i]   <= 1'b0;
        doneReg[i]   <= 1'b0;
        failReg[i]   <= 1'b0;
      end else begin
        if (strobes[i].wrBaseLo) baseReg[i][31:0]  <= wrData;
        if (strobes[i].wrBaseHi) baseReg[i][63:32] <= wrData;
        if (strobes[i].wrSizeLo) sizeReg[i][31:0]  <= wrData;
        if (strobes[i].wrSizeHi) sizeReg[i][63:32] <= wrData;
        if (strobes[i].wrCtrl) begin
          grainCode[i] <= wrData[CTL_GRAIN_LSB +: 4];
          waysCode[i]  <= wrData[CTL_WAYS_LSB +: 4];
          lockBit[i]   <= wrData[CTL_LOCK];
          commitReg[i] <= wrData[CTL_COMMIT];
          typeBit[i]   <= wrData[CTL_TYPE];
        end
        if (strobes[i].evalNow) begin
          doneReg[i] <= passAll[i];
          failReg[i] <= !passAll[i];
        end
        if (strobes[i].dropCommit) begin
          doneReg[i] <= 1'b0;
          failReg[i] <= 1'b0;
        end
      end
    end

    assign commitBit[i]    = commitReg[i];
    assign locked[i]       = lockBit[i] && doneReg[i];
    assign decCommitted[i] = doneReg[i];
    assign decBase[i*64 +: 64]      = doneReg[i] ? baseReg[i] : 64'd0;
    assign decSize[i*64 +: 64]      = doneReg[i] ? sizeReg[i] : 64'd0;
    assign decGranBytes[i*32 +: 32] = doneReg[i] ? grainBytes(grainCode[i]) : 32'd0;
    assign decWays[i*5 +: 5]        = doneReg[i] ? wayCount(waysCode[i]) : 5'd0;

    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(doneReg[i] && failReg[i]));
    // R5
    done_after_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneReg[i]) |-> $past(strobes[i].evalNow));
    // R8
    done_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneReg[i]) |-> $past(aligned));
    // R11
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
      locked[i] |=> $stable(baseReg[i]) && $stable(sizeReg[i]) &&
                    $stable(grainCode[i]) && $stable(waysCode[i]) && doneReg[i]);
    if (i > 0) begin : g_order_chk
      // R9
      order_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(doneReg[i]) |-> $past(doneReg[i-1]));
    end
  end

  always_comb begin
    rdData = 32'd0;
    if (addr == ADDR_W'(0)) rdData = CAP_WORD;
    if (addr == ADDR_W'(4)) rdData = {30'd0, enableReg, 1'b0};
    for (int i = 0; i < NUM_DEC; i++) begin
      if (addr == ADDR_W'(32*i + 16)) rdData = baseReg[i][31:0];
      if (addr == ADDR_W'(32*i + 20)) rdData = baseReg[i][63:32];
      if (addr == ADDR_W'(32*i + 24)) rdData = sizeReg[i][31:0];
      if (addr == ADDR_W'(32*i + 28)) rdData = sizeReg[i][63:32];
      if (addr == ADDR_W'(32*i + 32))
        rdData = {19'd0, typeBit[i], failReg[i], doneReg[i], commitReg[i],
                  lockBit[i], waysCode[i], grainCode[i]};
    end
  end

endmodule

// File: rtl/hdm_decoder_regs.sv
module hdm_decoder_regs
  import hdm_pkg::*;
#(
  parameter int NUM_DEC    = 4,
  parameter int ADDR_W     = 8,
  parameter int TGT_CNT    = 1,
  parameter bit SUP_LOW_IG = 1'b1,
  parameter bit SUP_HI_IG  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic [NUM_DEC-1:0]    decCommitted,
  output logic [NUM_DEC*64-1:0] decBase,
  output logic [NUM_DEC*64-1:0] decSize,
  output logic [NUM_DEC*32-1:0] decGranBytes,
  output logic [NUM_DEC*5-1:0]  decWays
);

  decStrobe_t         strobes [NUM_DEC];
  logic               globWr;
  logic [NUM_DEC-1:0] commitBit;
  logic [NUM_DEC-1:0] locked;

  hdm_ctrl #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .commitReqBit(wrData[CTL_COMMIT]), .commitBit(commitBit), .locked(locked),
    .strobes(strobes), .globWr(globWr)
  );

  hdm_datapath #(
    .NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W), .TGT_CNT(TGT_CNT),
    .SUP_LOW_IG(SUP_LOW_IG), .SUP_HI_IG(SUP_HI_IG)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .globWr(globWr),
    .wrData(wrData), .addr(addr), .rdData(rdData),
    .commitBit(commitBit), .locked(locked), .decCommitted(decCommitted),
    .decBase(decBase), .decSize(decSize), .decGranBytes(decGranBytes),
    .decWays(decWays)
  );

endmodule

// File: tb/test_hdm_decoder_regs.sv
`timescale 1ns/1ps
module test_hdm_decoder_regs;
  localparam int N = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [N-1:0] decCommitted;
  logic [N*64-1:0] decBase, decSize;
  logic [N*32-1:0] decGranBytes;
  logic [N*5-1:0] decWays;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hdm_decoder_regs i_hdm_decoder_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .decCommitted(decCommitted), .decBase(decBase),
    .decSize(decSize), .decGranBytes(decGranBytes), .decWays(decWays)
  );

  // Behavioural reference model
  logic [63:0] mBase [N];
  logic [63:0] mSize [N];
  int mG [N];
  int mW [N];
  bit mLock [N], mCmt [N], mCom [N], mErr [N], mPend [N];

  function automatic longint unsigned expGran(int g);
    return (g >= 0 && g <= 6) ? (256 * (2 ** g)) : 0;
  endfunction

  function automatic int expWays(int w);
    if (w <= 4) return 2 ** w;
    if (w >= 8 && w <= 10) return 3 * (2 ** (w - 8));
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mBase[i] = 0; mSize[i] = 0; mG[i] = 0; mW[i] = 0;
        mLock[i] = 0; mCmt[i] = 0; mCom[i] = 0; mErr[i] = 0; mPend[i] = 0;
      end
    end else begin
      bit ok [N];
      for (int i = 0; i < N; i++) begin
        ok[i] = (mG[i] <= 6) && (expWays(mW[i]) != 0) &&
                (mBase[i] % 64'h1000_0000 == 0) && (mSize[i] % 64'h1000_0000 == 0);
        if (i > 0) ok[i] = ok[i] && mCom[i-1] && (mBase[i] >= mBase[i-1] + mSize[i-1]);
      end
      for (int i = 0; i < N; i++)
        if (mPend[i]) begin mCom[i] = ok[i]; mErr[i] = !ok[i]; mPend[i] = 0; end
      if (wrEn) begin
        for (int i = 0; i < N; i++) begin
          if (!(mLock[i] && mCom[i])) begin
            if (int'(addr) == 32*i + 16) mBase[i][31:0]  = wrData;
            if (int'(addr) == 32*i + 20) mBase[i][63:32] = wrData;
            if (int'(addr) == 32*i + 24) mSize[i][31:0]  = wrData;
            if (int'(addr) == 32*i + 28) mSize[i][63:32] = wrData;
            if (int'(addr) == 32*i + 32) begin
              if (wrData[9] && !mCmt[i]) mPend[i] = 1;
              if (!wrData[9]) begin mCom[i] = 0; mErr[i] = 0; mPend[i] = 0; end
              mG[i] = int'(wrData[3:0]); mW[i] = int'(wrData[7:4]);
              mLock[i] = wrData[8]; mCmt[i] = wrData[9];
            end
          end
        end
      end
    end
  end

  // Compare all output buses against the model every cycle (R5)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit bad = 0;
      for (int i = 0; i < N; i++) begin
        if (decCommitted[i] !== mCom[i]) bad = 1;
        if (decBase[i*64 +: 64] !== (mCom[i] ? mBase[i] : 64'd0)) bad = 1;
        if (decSize[i*64 +: 64] !== (mCom[i] ? mSize[i] : 64'd0)) bad = 1;
        if (decGranBytes[i*32 +: 32] !== (mCom[i] ? 32'(expGran(mG[i])) : 32'd0)) bad = 1;
        if (decWays[i*5 +: 5] !== (mCom[i] ? 5'(expWays(mW[i])) : 5'd0)) bad = 1;
      end
      tests++;
      if (bad) begin
        fails++;
        $display("FAIL R5 outputs at %0t: committed act=%b exp=%b%b%b%b", $time,
                 decCommitted, mCom[3], mCom[2], mCom[1], mCom[0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a);
    #1;
    chk(tag, {32'd0, rdData}, {32'd0, exp});
  endtask

  function automatic int ctlOf(int i); return 32*i + 32; endfunction

  task automatic setRange(input int i, input logic [63:0] b, input logic [63:0] s);
    wr(32*i + 16, b[31:0]); wr(32*i + 20, b[63:32]);
    wr(32*i + 24, s[31:0]); wr(32*i + 28, s[63:32]);
  endtask

  // clear then arm commit with fields f (bits 8:0)
  task automatic tryCommit(input int i, input logic [31:0] f);
    wr(ctlOf(i), f & ~32'h200);
    wr(ctlOf(i), f | 32'h200);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state, R2 capability word
    rd(0, 32'h0000_0112, "R2 cap");
    rd(4, 32'h0, "R1 enable");
    for (int i = 0; i < N; i++) begin
      rd(ctlOf(i), 32'h0, "R1 ctrl");
      rd(32*i + 16, 32'h0, "R1 base");
    end
    chk("R1 committed", {60'd0, decCommitted}, 64'd0);

    // R3 enable register
    wr(4, 32'hFFFF_FFFF);
    rd(4, 32'h2, "R3 enable set");
    wr(4, 32'h0);
    rd(4, 32'h0, "R3 enable clr");

    // R4 readback
    setRange(0, 64'h1_0000_0000, 64'h2000_0000);
    rd(16, 32'h0, "R4 base lo");
    rd(20, 32'h1, "R4 base hi");
    rd(24, 32'h2000_0000, "R4 size lo");
    rd(28, 32'h0, "R4 size hi");
    wr(ctlOf(0), 32'h1000 | 32'h25);
    rd(ctlOf(0), 32'h1025, "R4 ctrl fields");

    // R6 every grain code
    for (int g = 0; g < 16; g++) begin
      tryCommit(0, 32'(g));
      rd(ctlOf(0), 32'(g) | 32'h200 | ((g <= 6) ? 32'h400 : 32'h800), "R6 grain result");
      chk("R6 grain bytes", {32'd0, decGranBytes[31:0]}, 64'(expGran(g)));
    end
    // R7 every ways code
    for (int w = 0; w < 16; w++) begin
      tryCommit(0, 32'(w) << 4);
      rd(ctlOf(0), (32'(w) << 4) | 32'h200 | ((expWays(w) != 0) ? 32'h400 : 32'h800),
         "R7 ways result");
      chk("R7 way count", {59'd0, decWays[4:0]}, 64'(expWays(w)));
    end

    // R10 clearing commit
    wr(ctlOf(0), 32'h0);
    rd(ctlOf(0), 32'h0, "R10 clear");

    // R8 alignment
    setRange(0, 64'h1_0000_1000, 64'h2000_0000);
    tryCommit(0, 32'h0);
    rd(ctlOf(0), 32'hA00, "R8 base misaligned");
    setRange(0, 64'h1_0000_0000, 64'h2000_0100);
    tryCommit(0, 32'h0);
    rd(ctlOf(0), 32'hA00, "R8 size misaligned");
    setRange(0, 64'h1_0000_0000, 64'h2000_0000);
    tryCommit(0, 32'h0);
    rd(ctlOf(0), 32'h600, "R8 aligned ok");

    // R9 ordering: decoder 2 while decoder 1 uncommitted
    setRange(2, 64'h4_0000_0000, 64'h1000_0000);
    tryCommit(2, 32'h0);
    rd(ctlOf(2), 32'hA00, "R9 predecessor uncommitted");
    // R9 base below end of decoder 0
    setRange(1, 64'h1_1000_0000, 64'h1000_0000);
    tryCommit(1, 32'h0);
    rd(ctlOf(1), 32'hA00, "R9 overlap");
    setRange(1, 64'h1_2000_0000, 64'h1000_0000);
    tryCommit(1, 32'h0);
    rd(ctlOf(1), 32'h600, "R9 flush ok");
    tryCommit(2, 32'h0);
    rd(ctlOf(2), 32'h600, "R9 chain ok");

    // R12 read-only result bits and no re-check without a fresh edge
    wr(ctlOf(3), 32'hC00);
    rd(ctlOf(3), 32'h0, "R12 result bits read-only");
    wr(ctlOf(1), 32'h201 | 32'hC00);
    rd(ctlOf(1), 32'h601, "R12 no new check");

    // R11 lock
    tryCommit(0, 32'h100);
    rd(ctlOf(0), 32'h700, "R11 locked commit");
    wr(16, 32'hDEAD_0000);
    wr(20, 32'h0000_00FF);
    wr(24, 32'h1234_0000);
    wr(ctlOf(0), 32'h0);
    rd(16, 32'h0, "R11 base lo kept");
    rd(20, 32'h1, "R11 base hi kept");
    rd(24, 32'h2000_0000, "R11 size kept");
    rd(ctlOf(0), 32'h700, "R11 ctrl kept");
    chk("R11 still committed", {63'd0, decCommitted[0]}, 64'd1);

    // R1 reset removes lock
    doReset();
    rd(ctlOf(0), 32'h0, "R1 lock cleared");
    rd(16, 32'h0, "R1 base cleared");
    wr(16, 32'h1000_0000);
    rd(16, 32'h1000_0000, "R1 writable after reset");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule